// File: doc/BRIEF.md
# Two-Class Prioritised Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 to 15, and tells one processor which request to serve next as a 4-bit number. A rising edge on a line latches a request, either in a pending register shared by all processors or, when the line's broadcast selector bit is set, in the force register of every processor. Software can also raise requests directly through per-processor force registers. Each line is enabled by a mask bit and placed in either the high or the low priority class.

Delivery goes to processor 0. The active set is (pending OR force of processor 0) AND mask of processor 0. If any active source is in the high class, the output shows the highest-numbered source in that class. Otherwise it shows the highest-numbered active source in the low class. The processor acknowledges a request by number, which clears that bit from pending and from its own force register. Software reaches all registers through a 32-bit word port. Reads are registered.

Top module: `twoclass_irq_ctrl`

## Requirements
- R1: The byte offset is the address taken modulo 256; address bits above bit 7 are ignored. The map is: 0x00 class select, 0x04 pending, 0x08 processor-0 force replace, 0x0C pending clear, 0x10 status, 0x14 broadcast select, 0x40+4k mask of processor k, 0x80+4k force of processor k.
- R2: Bit 0 and bits 31:16 of every stored register are always zero. A read returns the 16-bit value zero-extended.
- R3: A rising edge on line n (1..15) sets bit n of pending when broadcast bit n is 0. When broadcast bit n is 1, it sets bit n in every processor's force register and leaves pending unchanged. A line held high does not set a bit again.
- R4: With active = (pending | force0) & mask0, the output is the highest set index of active & select when that is nonzero, else the highest set index of active & ~select, else 0. A bit at 1 in the select register puts a source in the high class. The output reflects the state written by the same clock edge.
- R5: A write to the force register of processor k sets the bits given in wdata[15:1] and clears the bits given in wdata[31:17]: new = (old | set) & ~clear.
- R6: A write to offset 0x08 replaces processor 0's force register with wdata[15:1], with no set/clear meaning.
- R7: A write to 0x0C clears the pending bits given in wdata[15:1]. Offsets 0x0C and 0x10 read as zero. Writes to 0x04 have no effect.
- R8: An acknowledge with number n clears bit n of pending and of processor 0's force register.
- R9: When a rising edge and a software clear or an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R10: Reset (synchronous, active high) clears every register. The output becomes 0.
- R11: Mask and force slots numbered NCPU or higher read as zero, and writes to them have no effect.
- R12: Read data appears on bus_rdata in the cycle after the read strobe. It shows the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 16 | Interrupt request lines; bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Number being acknowledged |
| cpu_level | output | 4 | Number of the request to serve, 0 if none |

## Verification
The bench targets collisions in a single cycle. A rising edge that meets a pending clear, or that meets an acknowledge, is checked; a design that let the clear win would lose a fresh request. The bench uses a high-class source with a lower number than an active low-class source. A design that only took the highest number would report the wrong source. Other checks cover the two force write styles, broadcast routing into every slot, slots beyond the processor count, and addresses above 255. A design that mixed up replace and set/clear, aliased unused slots onto real ones, or decoded the upper address bits would return wrong read data or a wrong output.

// File: rtl/twoclass_irq_pkg.sv
package twoclass_irq_pkg;
  localparam int SRC_W = 16;
  localparam logic [SRC_W-1:0] SRC_VALID = 16'hFFFE;

  localparam logic [7:0] OFS_CLASS  = 8'h00;
  localparam logic [7:0] OFS_PEND   = 8'h04;
  localparam logic [7:0] OFS_REPL0  = 8'h08;
  localparam logic [7:0] OFS_PCLR   = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_BCAST  = 8'h14;
  localparam logic [1:0] REGION_MASK  = 2'b01;
  localparam logic [1:0] REGION_FORCE = 2'b10;

  function automatic logic [3:0] top_index(input logic [SRC_W-1:0] v);
    logic [3:0] idx;
    idx = '0;
    for (int i = 1; i < SRC_W; i++) begin
      if (v[i]) idx = 4'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/tci_edge_detect.sv
module tci_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines;
  end

  assign rise = lines & ~prev_q;
endmodule

// File: rtl/tci_force_slot.sv
module tci_force_slot
  import twoclass_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             setclr_wr,
  input  logic             repl_wr,
  input  logic [31:0]      wdata,
  input  logic [SRC_W-1:0] ack_clr,
  input  logic [SRC_W-1:0] bc_set,
  output logic [SRC_W-1:0] q,
  output logic [SRC_W-1:0] d
);
  logic [SRC_W-1:0] set_bits, clr_bits, after_wr;

  assign set_bits = wdata[15:0]  & SRC_VALID;
  assign clr_bits = wdata[31:16] & SRC_VALID;

  always_comb begin
    after_wr = q;
    if (setclr_wr) after_wr = (q | set_bits) & ~clr_bits;
    if (repl_wr)   after_wr = set_bits;
    d = ((after_wr & ~ack_clr) | bc_set) & SRC_VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/tci_prio_sel.sv
module tci_prio_sel
  import twoclass_irq_pkg::*;
(
  input  logic [SRC_W-1:0] pend,
  input  logic [SRC_W-1:0] force_bits,
  input  logic [SRC_W-1:0] mask,
  input  logic [SRC_W-1:0] hi_class,
  output logic [3:0]       level
);
  logic [SRC_W-1:0] act, hi, lo;

  assign act   = (pend | force_bits) & mask;
  assign hi    = act & hi_class;
  assign lo    = act & ~hi_class;
  assign level = (|hi) ? top_index(hi) : top_index(lo);
endmodule

// File: rtl/twoclass_irq_ctrl.sv
module twoclass_irq_ctrl
  import twoclass_irq_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       irq_lines,
  input  logic              ack_valid,
  input  logic [3:0]        ack_num,
  output logic [3:0]        cpu_level
);
  localparam int SLOT_W = 4;

  logic [7:0]        ofs;
  logic [1:0]        region;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;
  logic              wr_class, wr_repl, wr_pclr, wr_bcast, wr_mask, wr_force;

  logic [SRC_W-1:0] class_q, pend_q, bcast_q;
  logic [SRC_W-1:0] class_d, pend_d, bcast_d, mask0_d;
  logic [SRC_W-1:0] mask_q  [NCPU];
  logic [SRC_W-1:0] force_q [NCPU];
  logic [SRC_W-1:0] force_d [NCPU];
  logic [SRC_W-1:0] edge_rise, ack_bit, clr_bits, wsrc;
  logic [SRC_W-1:0] force0_q, mask0_q;
  logic [3:0]       level_d;
  logic [31:0]      rd_val;

  assign ofs     = bus_addr[7:0];
  assign region  = ofs[7:6];
  assign slot    = ofs[5:2];
  assign slot_ok = int'(slot) < NCPU;
  assign wsrc    = bus_wdata[15:0] & SRC_VALID;

  assign wr_class = bus_wr && (ofs == OFS_CLASS);
  assign wr_repl  = bus_wr && (ofs == OFS_REPL0);
  assign wr_pclr  = bus_wr && (ofs == OFS_PCLR);
  assign wr_bcast = bus_wr && (ofs == OFS_BCAST);
  assign wr_mask  = bus_wr && (region == REGION_MASK)  && slot_ok;
  assign wr_force = bus_wr && (region == REGION_FORCE) && slot_ok;

  tci_edge_detect #(.W(SRC_W)) u_edge (
    .clk(clk), .rst(rst), .lines(irq_lines & SRC_VALID), .rise(edge_rise)
  );

  assign ack_bit  = ack_valid ? ((16'h1 << ack_num) & SRC_VALID) : '0;
  assign clr_bits = wr_pclr ? wsrc : '0;
  assign pend_d   = ((pend_q & ~clr_bits & ~ack_bit) | (edge_rise & ~bcast_q)) & SRC_VALID;
  assign class_d  = wr_class ? wsrc : class_q;
  assign bcast_d  = wr_bcast ? wsrc : bcast_q;
  assign mask0_d  = (wr_mask && slot == '0) ? wsrc : mask_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q <= '0;
      pend_q  <= '0;
      bcast_q <= '0;
    end else begin
      class_q <= class_d;
      pend_q  <= pend_d;
      bcast_q <= bcast_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCPU; g++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (rst)                                    mask_q[g] <= '0;
        else if (wr_mask && slot == SLOT_W'(g))     mask_q[g] <= wsrc;
      end

      tci_force_slot u_force (
        .clk       (clk),
        .rst       (rst),
        .setclr_wr (wr_force && slot == SLOT_W'(g)),
        .repl_wr   ((g == 0) ? wr_repl : 1'b0),
        .wdata     (bus_wdata),
        .ack_clr   ((g == 0) ? ack_bit : '0),
        .bc_set    (edge_rise & bcast_q),
        .q         (force_q[g]),
        .d         (force_d[g])
      );
    end
  endgenerate

  assign force0_q = force_q[0];
  assign mask0_q  = mask_q[0];

  tci_prio_sel u_sel (
    .pend(pend_d), .force_bits(force_d[0]), .mask(mask0_d),
    .hi_class(class_d), .level(level_d)
  );

  always_comb begin
    rd_val = '0;
    case (ofs)
      OFS_CLASS: rd_val = {16'h0, class_q};
      OFS_PEND:  rd_val = {16'h0, pend_q};
      OFS_REPL0: rd_val = {16'h0, force_q[0]};
      OFS_BCAST: rd_val = {16'h0, bcast_q};
      default: begin
        if (slot_ok && region == REGION_MASK)  rd_val = {16'h0, mask_q[slot]};
        if (slot_ok && region == REGION_FORCE) rd_val = {16'h0, force_q[slot]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_level <= '0;
      bus_rdata <= '0;
    end else begin
      cpu_level <= level_d;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/tci_checker.sv
module tci_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ack_valid,
  input logic [3:0]        ack_num,
  input logic [15:0]       edge_rise,
  input logic [15:0]       pend_q,
  input logic [15:0]       force0_q,
  input logic [15:0]       mask0_q,
  input logic [15:0]       class_q,
  input logic [15:0]       bcast_q,
  input logic [3:0]        cpu_level
);
  logic [15:0] act;
  assign act = (pend_q | force0_q) & mask0_q;

  // R2
  bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q[0] == 1'b0) && (force0_q[0] == 1'b0) && (mask0_q[0] == 1'b0));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[7:0] == 8'h0C && edge_rise == 16'h0 && !ack_valid)
    |=> ((pend_q & $past(bus_wdata[15:0]) & 16'hFFFE) == 16'h0));

  // R7
  zero_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[7:0] == 8'h0C || bus_addr[7:0] == 8'h10)) |=> (bus_rdata == 32'h0));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !bus_wr && edge_rise == 16'h0)
    |=> (!pend_q[$past(ack_num)] && !force0_q[$past(ack_num)]));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((edge_rise & ~bcast_q) != 16'h0)
    |=> ((pend_q & $past(edge_rise & ~bcast_q)) == $past(edge_rise & ~bcast_q)));

  // R4
  level_active_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_level != 4'd0) |-> act[cpu_level]);

  // R4
  high_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((act & class_q) != 16'h0) |-> class_q[cpu_level]);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act == 16'h0) |-> (cpu_level == 4'd0));
endmodule

bind twoclass_irq_ctrl tci_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_valid(ack_valid),
  .ack_num(ack_num), .edge_rise(edge_rise), .pend_q(pend_q), .force0_q(force0_q),
  .mask0_q(mask0_q), .class_q(class_q), .bcast_q(bcast_q), .cpu_level(cpu_level)
);

// File: tb/twoclass_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module twoclass_irq_ctrl_tb_top;
  localparam int NCPU   = 4;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [15:0]       irq_lines = '0;
  logic              ack_valid = 1'b0;
  logic [3:0]        ack_num = '0;
  logic [3:0]        cpu_level;

  always #5 clk = ~clk;

  twoclass_irq_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .ack_valid(ack_valid), .ack_num(ack_num), .cpu_level(cpu_level)
  );

  // reference model state
  logic [15:0] m_class, m_pend, m_bcast, m_prev;
  logic [15:0] m_mask [16];
  logic [15:0] m_force [16];
  logic [3:0]  exp_level;
  logic [31:0] exp_rdata;
  bit          exp_rd_valid = 0;
  bit          started = 0;
  bit          done = 0;
  int          checks = 0, errors = 0;
  string       cur_req = "R10";

  function automatic logic [3:0] hi_idx(input logic [15:0] v);
    logic [3:0] r = 0;
    for (int i = 15; i >= 1; i--) if (v[i] && r == 0) r = 4'(i);
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int k = a[5:2];
    if (a == 8'h00) return {16'h0, m_class};
    if (a == 8'h04) return {16'h0, m_pend};
    if (a == 8'h08) return {16'h0, m_force[0]};
    if (a == 8'h14) return {16'h0, m_bcast};
    if (a >= 8'h40 && a < 8'h80 && k < NCPU) return {16'h0, m_mask[k]};
    if (a >= 8'h80 && a < 8'hC0 && k < NCPU) return {16'h0, m_force[k]};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] rise, ackb, w, route_bc;
    logic [7:0]  a;
    logic [15:0] act;
    int k;
    started = 1;
    if (rst) begin
      m_class = 0; m_pend = 0; m_bcast = 0; m_prev = 0;
      for (int i = 0; i < 16; i++) begin m_mask[i] = 0; m_force[i] = 0; end
      exp_level = 0; exp_rd_valid = 0;
    end else begin
      a = bus_addr[7:0];
      k = a[5:2];
      exp_rd_valid = bus_rd;
      if (bus_rd) exp_rdata = model_read(a);
      rise = irq_lines & ~m_prev & 16'hFFFE;
      m_prev = irq_lines;
      ackb = ack_valid ? ((16'h1 << ack_num) & 16'hFFFE) : 16'h0;
      route_bc = rise & m_bcast;
      w = bus_wdata[15:0] & 16'hFFFE;
      if (bus_wr) begin
        if (a == 8'h00) m_class = w;
        else if (a == 8'h08) m_force[0] = w;
        else if (a == 8'h0C) m_pend = m_pend & ~w;
        else if (a == 8'h14) m_bcast = w;
        else if (a >= 8'h40 && a < 8'h80 && k < NCPU) m_mask[k] = w;
        else if (a >= 8'h80 && a < 8'hC0 && k < NCPU)
          m_force[k] = (m_force[k] | w) & ~(bus_wdata[31:16] & 16'hFFFE);
      end
      m_pend = (m_pend & ~ackb) | (rise & ~route_bc);
      m_force[0] = m_force[0] & ~ackb;
      for (int i = 0; i < NCPU; i++) m_force[i] = m_force[i] | route_bc;
      act = (m_pend | m_force[0]) & m_mask[0];
      exp_level = ((act & m_class) != 0) ? hi_idx(act & m_class) : hi_idx(act & ~m_class);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (cpu_level !== exp_level) begin
        errors++;
        $display("FAIL %s cpu_level actual=%0d expected=%0d", cur_req, cpu_level, exp_level);
      end
      if (exp_rd_valid) begin
        checks++;
        if (bus_rdata !== exp_rdata) begin
          errors++;
          $display("FAIL %s (R12) rdata actual=%h expected=%h", cur_req, bus_rdata, exp_rdata);
        end
      end
    end
  end

  task automatic lit(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s literal actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    lit(tag, bus_rdata, expv);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_lines[n] = 1;
    @(negedge clk); @(negedge clk); irq_lines[n] = 0;
  endtask

  task automatic ack(input int n);
    @(negedge clk); ack_valid = 1; ack_num = 4'(n);
    @(negedge clk); ack_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R10";
    lit("R10", {28'h0, cpu_level}, 0);
    rd(12'h000, 0, "R10"); rd(12'h040, 0, "R10"); rd(12'h080, 0, "R10");

    cur_req = "R2";
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h0000_FFFE, "R2");

    cur_req = "R3";
    pulse(5); idle(1);
    lit("R3", {28'h0, cpu_level}, 5);
    rd(12'h004, 32'h0020, "R3");
    @(negedge clk); irq_lines[6] = 1; idle(4);
    ack(6); idle(2);
    rd(12'h004, 32'h0020, "R3");
    irq_lines[6] = 0;
    pulse(3); idle(1);
    lit("R4", {28'h0, cpu_level}, 5);

    cur_req = "R4";
    wr(12'h000, 32'h0000_0008);
    lit("R4", {28'h0, cpu_level}, 3);

    cur_req = "R8";
    ack(3);
    lit("R8", {28'h0, cpu_level}, 5);

    cur_req = "R3";
    wr(12'h014, 32'h0000_0200);
    pulse(9); idle(1);
    lit("R3", {28'h0, cpu_level}, 9);
    rd(12'h08C, 32'h0200, "R3");
    rd(12'h004, 32'h0020, "R3");

    cur_req = "R5";
    wr(12'h084, 32'h0000_0006);
    wr(12'h084, 32'h0004_0000);
    rd(12'h084, 32'h0202, "R5");

    cur_req = "R6";
    wr(12'h008, 32'h0004_0100);
    rd(12'h080, 32'h0100, "R6");
    lit("R6", {28'h0, cpu_level}, 8);

    cur_req = "R7";
    wr(12'h00C, 32'h0000_0020);
    rd(12'h004, 32'h0, "R7");
    wr(12'h004, 32'h0000_FFFF);
    rd(12'h004, 32'h0, "R7");
    rd(12'h00C, 32'h0, "R7");
    rd(12'h010, 32'h0, "R7");

    cur_req = "R9";
    @(negedge clk); irq_lines[7] = 1; bus_wr = 1; bus_addr = 12'h00C; bus_wdata = 32'h80;
    @(negedge clk); bus_wr = 0;
    rd(12'h004, 32'h0080, "R9");
    irq_lines[7] = 0; idle(1);
    @(negedge clk); irq_lines[7] = 1; ack_valid = 1; ack_num = 7;
    @(negedge clk); ack_valid = 0;
    rd(12'h004, 32'h0080, "R9");
    irq_lines[7] = 0;

    cur_req = "R11";
    wr(12'h054, 32'h0000_FFFF);
    wr(12'h09C, 32'h0000_FFFF);
    rd(12'h054, 32'h0, "R11");
    rd(12'h09C, 32'h0, "R11");
    rd(12'h040, 32'hFFFE, "R11");

    cur_req = "R1";
    wr(12'h340, 32'h0000_0000);
    rd(12'h040, 32'h0, "R1");
    lit("R1", {28'h0, cpu_level}, 0);
    wr(12'hE40, 32'h0000_00F0);

    cur_req = "R12";
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [7:0] addrs [10];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h40, 8'h44, 8'h80, 8'h88, 8'hB0};
      @(negedge clk);
      irq_lines = $urandom & 16'hFFFF;
      sel = $urandom % 4;
      bus_wr = (sel == 0);
      bus_rd = (sel == 1);
      bus_addr = {4'($urandom % 16), addrs[$urandom % 10]};
      bus_wdata = $urandom;
      ack_valid = ($urandom % 3) == 0;
      ack_num = 4'($urandom);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ack_valid = 0; irq_lines = 0;
    idle(2);

    cur_req = "R10";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    lit("R10", {28'h0, cpu_level}, 0);
    rd(12'h004, 32'h0, "R10");
    rd(12'h080, 32'h0, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule